// File: doc/BRIEF.md
# Multi-cycle instruction sequencing controller

This block is the control unit of a processor whose datapath shares one memory, one ALU and one register file across several clock cycles per instruction. It is a Moore state machine. Every instruction begins with a fetch cycle and a decode cycle. The decode cycle reads both source registers and forms a branch target before the instruction class is known. The controller then steps through the cycles that belong to the opcode: register-register operations, loads, stores, equal-branches and jumps. Each instruction takes two to five cycles. The block also holds the small decoder that turns the ALU mode and the function field into an ALU operation code.

The select, enable and write-strobe outputs come from flip-flops. They are loaded with the values that belong to the state being entered, so every control line leaves the block glitch-free one register away from the clock. The datapath keeps the opcode and function field in its instruction register, so both inputs stay stable for the whole instruction.

Top module: `mc_seq_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the controller in the fetch cycle, both when it is released and when it is applied in the middle of an instruction. The next cycle after release shows the fetch outputs.
- R2: The fetch cycle drives the following values:
  - mem_rd=1, ir_load=1 and pc_load=1
  - addr_sel=0, opa_sel=0 (PC) and opb_sel=01 (constant 4)
  - alu_mode=00 (add) and pc_next_sel=00 (ALU result)
- R3: Every fetch is followed by a decode cycle with opa_sel=0 and opb_sel=11 (shifted immediate). All other control outputs in decode are 0.
- R4: After decode, a load (opcode 100011) or a store (opcode 101011) goes to an address cycle with opa_sel=1, opb_sel=10 (immediate) and alu_mode=00.
- R5: The memory cycle drives addr_sel=1 (data address). A load also drives mem_rd=1. A store drives mem_wr=1 and then returns to fetch. mem_rd and mem_wr are never 1 together.
- R6: A load has a fifth cycle that writes back to the register file, with rf_we=1, wr_data_sel=1 (memory data) and wr_dst_sel=0 (rt field). It then returns to fetch.
- R7: A register-register instruction (opcode 000000) has an execute cycle with opa_sel=1, opb_sel=00 (register B) and alu_mode=10. This is followed by a completion cycle with rf_we=1, wr_dst_sel=1 (rd field) and wr_data_sel=0, and then fetch.
- R8: A branch-equal (opcode 000100) has one cycle with opa_sel=1, opb_sel=00, alu_mode=01 (subtract), pc_load_zero=1 and pc_next_sel=01 (ALU output register). It then returns to fetch.
- R9: A jump (opcode 000010) has one cycle with pc_load=1 and pc_next_sel=10 (jump address). It then returns to fetch.
- R10: Any other opcode returns to fetch directly after decode.
- R11: alu_fn uses the codes 0=add, 1=subtract, 2=AND, 3=OR and 4=set-less-than. It is decoded as follows:
  - alu_mode 00 or 11 gives add, and alu_mode 01 gives subtract, whatever the value of funct.
  - alu_mode 10 maps funct 100000, 100010, 100100, 100101 and 101010 to add, subtract, AND, OR and set-less-than.
  - alu_mode 10 with any other funct gives add.
- R12: In every cycle, each control output not named for that cycle above is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register |
| funct | input | 6 | Function field of the instruction register |
| addr_sel | output | 1 | Memory address select: 0 = PC, 1 = ALU output register |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_load | output | 1 | Instruction register load |
| opa_sel | output | 1 | ALU first operand: 0 = PC, 1 = register A |
| opb_sel | output | 2 | ALU second operand: 00 = B, 01 = 4, 10 = immediate, 11 = shifted immediate |
| alu_mode | output | 2 | 00 = add, 01 = subtract, 10 = use funct |
| pc_load | output | 1 | Unconditional PC write |
| pc_load_zero | output | 1 | PC write qualified by ALU zero |
| pc_next_sel | output | 2 | PC source: 00 = ALU result, 01 = ALU output register, 10 = jump address |
| wr_dst_sel | output | 1 | Register write address: 0 = rt, 1 = rd |
| rf_we | output | 1 | Register file write enable |
| wr_data_sel | output | 1 | Register write data: 0 = ALU output register, 1 = memory data |
| alu_fn | output | 3 | ALU operation code (R11) |

## Verification
The assertions assume that opcode and funct stay constant from the fetch cycle to the last cycle of each instruction, just as the instruction register holds them in a real datapath. The ordering properties, such as a write strobe being followed by fetch or a write-back being preceded by a read, depend on that. The stimulus changes opcode and funct only in the fetch cycle, a little after the clock edge. Reset is applied and released only at those same points, so the controller is never seen with inputs that change in the middle of an instruction.

// File: rtl/mc_seq_pkg.sv
package mc_seq_pkg;

  localparam int ALU_FN_W = 3;

  typedef enum logic [3:0] {
    ST_FETCH, ST_DECODE, ST_ADDR, ST_LDMEM, ST_LDWB,
    ST_STMEM, ST_EXEC, ST_RRWB, ST_BRANCH, ST_JUMP
  } step_t;

  typedef enum logic [ALU_FN_W-1:0] {
    FN_ADD = 3'd0, FN_SUB = 3'd1, FN_AND = 3'd2, FN_OR = 3'd3, FN_SLT = 3'd4
  } alu_fn_t;

  typedef struct packed {
    logic       addr_sel;
    logic       mem_rd;
    logic       mem_wr;
    logic       ir_load;
    logic       opa_sel;
    logic [1:0] opb_sel;
    logic [1:0] alu_mode;
    logic       pc_load;
    logic       pc_load_zero;
    logic [1:0] pc_next_sel;
    logic       wr_dst_sel;
    logic       rf_we;
    logic       wr_data_sel;
  } ctl_t;

  // Control word presented while the machine sits in a given step
  function automatic ctl_t ctl_for(step_t s);
    ctl_t c;
    c = '0;
    case (s)
      ST_FETCH: begin
        c.mem_rd  = 1'b1;
        c.ir_load = 1'b1;
        c.opb_sel = 2'b01;
        c.pc_load = 1'b1;
      end
      ST_DECODE: c.opb_sel = 2'b11;
      ST_ADDR: begin
        c.opa_sel = 1'b1;
        c.opb_sel = 2'b10;
      end
      ST_LDMEM: begin
        c.addr_sel = 1'b1;
        c.mem_rd   = 1'b1;
      end
      ST_LDWB: begin
        c.rf_we       = 1'b1;
        c.wr_data_sel = 1'b1;
      end
      ST_STMEM: begin
        c.addr_sel = 1'b1;
        c.mem_wr   = 1'b1;
      end
      ST_EXEC: begin
        c.opa_sel  = 1'b1;
        c.alu_mode = 2'b10;
      end
      ST_RRWB: begin
        c.rf_we      = 1'b1;
        c.wr_dst_sel = 1'b1;
      end
      ST_BRANCH: begin
        c.opa_sel      = 1'b1;
        c.alu_mode     = 2'b01;
        c.pc_load_zero = 1'b1;
        c.pc_next_sel  = 2'b01;
      end
      ST_JUMP: begin
        c.pc_load     = 1'b1;
        c.pc_next_sel = 2'b10;
      end
      default: c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/mc_seq_next.sv
module mc_seq_next
  import mc_seq_pkg::*;
#(
  parameter int              OPW    = 6,
  parameter logic [OPW-1:0]  OP_RR  = 6'b000000,
  parameter logic [OPW-1:0]  OP_LD  = 6'b100011,
  parameter logic [OPW-1:0]  OP_ST  = 6'b101011,
  parameter logic [OPW-1:0]  OP_BEQ = 6'b000100,
  parameter logic [OPW-1:0]  OP_JMP = 6'b000010
) (
  input  step_t          cur,
  input  logic [OPW-1:0] opcode,
  output step_t          nxt
);

  always_comb begin
    nxt = ST_FETCH;
    case (cur)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: begin
        if (opcode == OP_RR)                         nxt = ST_EXEC;
        else if (opcode == OP_LD || opcode == OP_ST) nxt = ST_ADDR;
        else if (opcode == OP_BEQ)                   nxt = ST_BRANCH;
        else if (opcode == OP_JMP)                   nxt = ST_JUMP;
        else                                         nxt = ST_FETCH;
      end
      ST_ADDR:   nxt = (opcode == OP_LD) ? ST_LDMEM : ST_STMEM;
      ST_LDMEM:  nxt = ST_LDWB;
      ST_EXEC:   nxt = ST_RRWB;
      default:   nxt = ST_FETCH;
    endcase
  end

endmodule

// File: rtl/mc_seq_state.sv
module mc_seq_state
  import mc_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  step_t nxt,
  output step_t cur,
  output ctl_t  ctl
);

  // Outputs are loaded with the word of the step being entered,
  // so they stay aligned with the state and come straight from flops.
  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= ST_FETCH;
      ctl <= ctl_for(ST_FETCH);
    end else begin
      cur <= nxt;
      ctl <= ctl_for(nxt);
    end
  end

endmodule

// File: rtl/mc_alu_dec.sv
module mc_alu_dec
  import mc_seq_pkg::*;
#(
  parameter int             FNW    = 6,
  parameter logic [FNW-1:0] FC_ADD = 6'b100000,
  parameter logic [FNW-1:0] FC_SUB = 6'b100010,
  parameter logic [FNW-1:0] FC_AND = 6'b100100,
  parameter logic [FNW-1:0] FC_OR  = 6'b100101,
  parameter logic [FNW-1:0] FC_SLT = 6'b101010
) (
  input  logic [1:0]     alu_mode,
  input  logic [FNW-1:0] funct,
  output alu_fn_t        alu_fn
);

  alu_fn_t from_funct;

  always_comb begin
    case (funct)
      FC_ADD:  from_funct = FN_ADD;
      FC_SUB:  from_funct = FN_SUB;
      FC_AND:  from_funct = FN_AND;
      FC_OR:   from_funct = FN_OR;
      FC_SLT:  from_funct = FN_SLT;
      default: from_funct = FN_ADD;
    endcase
  end

  always_comb begin
    case (alu_mode)
      2'b01:   alu_fn = FN_SUB;
      2'b10:   alu_fn = from_funct;
      default: alu_fn = FN_ADD;
    endcase
  end

endmodule

// File: rtl/mc_seq_ctrl.sv
module mc_seq_ctrl
  import mc_seq_pkg::*;
#(
  parameter int             OPW    = 6,
  parameter int             FNW    = 6,
  parameter logic [OPW-1:0] OP_RR  = 6'b000000,
  parameter logic [OPW-1:0] OP_LD  = 6'b100011,
  parameter logic [OPW-1:0] OP_ST  = 6'b101011,
  parameter logic [OPW-1:0] OP_BEQ = 6'b000100,
  parameter logic [OPW-1:0] OP_JMP = 6'b000010
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [OPW-1:0]      opcode,
  input  logic [FNW-1:0]      funct,
  output logic                addr_sel,
  output logic                mem_rd,
  output logic                mem_wr,
  output logic                ir_load,
  output logic                opa_sel,
  output logic [1:0]          opb_sel,
  output logic [1:0]          alu_mode,
  output logic                pc_load,
  output logic                pc_load_zero,
  output logic [1:0]          pc_next_sel,
  output logic                wr_dst_sel,
  output logic                rf_we,
  output logic                wr_data_sel,
  output logic [ALU_FN_W-1:0] alu_fn
);

  step_t   cur_st, nxt_st;
  ctl_t    ctl;
  alu_fn_t fn;

  mc_seq_next #(
    .OPW(OPW), .OP_RR(OP_RR), .OP_LD(OP_LD), .OP_ST(OP_ST),
    .OP_BEQ(OP_BEQ), .OP_JMP(OP_JMP)
  ) next_i (
    .cur(cur_st), .opcode(opcode), .nxt(nxt_st)
  );

  mc_seq_state state_i (
    .clk(clk), .rst(rst), .nxt(nxt_st), .cur(cur_st), .ctl(ctl)
  );

  mc_alu_dec #(.FNW(FNW)) alu_dec_i (
    .alu_mode(ctl.alu_mode), .funct(funct), .alu_fn(fn)
  );

  assign addr_sel     = ctl.addr_sel;
  assign mem_rd       = ctl.mem_rd;
  assign mem_wr       = ctl.mem_wr;
  assign ir_load      = ctl.ir_load;
  assign opa_sel      = ctl.opa_sel;
  assign opb_sel      = ctl.opb_sel;
  assign alu_mode     = ctl.alu_mode;
  assign pc_load      = ctl.pc_load;
  assign pc_load_zero = ctl.pc_load_zero;
  assign pc_next_sel  = ctl.pc_next_sel;
  assign wr_dst_sel   = ctl.wr_dst_sel;
  assign rf_we        = ctl.rf_we;
  assign wr_data_sel  = ctl.wr_data_sel;
  assign alu_fn       = fn;

  // Decode always follows fetch and never reloads the instruction register
  assert_fetch_then_decode_R3: assert property (@(posedge clk) disable iff (rst)
    ir_load |=> (!ir_load && opb_sel == 2'b11 && !opa_sel));

  // Read and write strobes are mutually exclusive
  assert_mem_strobe_excl_R5: assert property (@(posedge clk) disable iff (rst)
    $countones({mem_rd, mem_wr}) <= 1 || (ir_load == 1'b0 && 1'b0));

  // A store's write cycle is the last of the instruction
  assert_store_ends_R5: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> ir_load);

  // Load write-back is preceded by a data-address read
  assert_load_wb_after_read_R6: assert property (@(posedge clk) disable iff (rst)
    (rf_we && wr_data_sel) |-> $past(mem_rd && addr_sel));

  // Any register write-back ends the instruction
  assert_wb_ends_R7: assert property (@(posedge clk) disable iff (rst)
    rf_we |=> ir_load);

  // Branch cycle ends the instruction
  assert_branch_ends_R8: assert property (@(posedge clk) disable iff (rst)
    pc_load_zero |=> ir_load);

  // Jump cycle ends the instruction
  assert_jump_ends_R9: assert property (@(posedge clk) disable iff (rst)
    (pc_load && pc_next_sel == 2'b10) |=> ir_load);

  // Subtract mode reaches the ALU code regardless of funct
  assert_sub_mode_R11: assert property (@(posedge clk) disable iff (rst)
    (alu_mode == 2'b01) |-> (alu_fn == FN_SUB));

endmodule

// File: tb/mc_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module mc_seq_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'd0;
  logic [5:0] funct = 6'd0;
  logic addr_sel, mem_rd, mem_wr, ir_load, opa_sel, pc_load, pc_load_zero;
  logic wr_dst_sel, rf_we, wr_data_sel;
  logic [1:0] opb_sel, alu_mode, pc_next_sel;
  logic [2:0] alu_fn;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  mc_seq_ctrl dut_i (
    .clk(clk), .rst(rst), .opcode(opcode), .funct(funct),
    .addr_sel(addr_sel), .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_load(ir_load),
    .opa_sel(opa_sel), .opb_sel(opb_sel), .alu_mode(alu_mode),
    .pc_load(pc_load), .pc_load_zero(pc_load_zero), .pc_next_sel(pc_next_sel),
    .wr_dst_sel(wr_dst_sel), .rf_we(rf_we), .wr_data_sel(wr_data_sel),
    .alu_fn(alu_fn)
  );

  logic [18:0] act;
  assign act = {addr_sel, mem_rd, mem_wr, ir_load, opa_sel, opb_sel, alu_mode,
                pc_load, pc_load_zero, pc_next_sel, wr_dst_sel, rf_we,
                wr_data_sel, alu_fn};

  localparam int S_F = 0, S_D = 1, S_MA = 2, S_MR = 3, S_LW = 4,
                 S_MW = 5, S_EX = 6, S_RW = 7, S_BR = 8, S_J = 9;

  // Bit order: addr,rd,wr,ir,opa,opb[2],mode[2],pc,pcz,pcsel[2],dst,we,wdata
  function automatic logic [15:0] exp_vec(int s);
    case (s)
      S_F:  return 16'b0_1_0_1_0_01_00_1_0_00_0_0_0;
      S_D:  return 16'b0_0_0_0_0_11_00_0_0_00_0_0_0;
      S_MA: return 16'b0_0_0_0_1_10_00_0_0_00_0_0_0;
      S_MR: return 16'b1_1_0_0_0_00_00_0_0_00_0_0_0;
      S_LW: return 16'b0_0_0_0_0_00_00_0_0_00_0_1_1;
      S_MW: return 16'b1_0_1_0_0_00_00_0_0_00_0_0_0;
      S_EX: return 16'b0_0_0_0_1_00_10_0_0_00_0_0_0;
      S_RW: return 16'b0_0_0_0_0_00_00_0_0_00_1_1_0;
      S_BR: return 16'b0_0_0_0_1_00_01_0_1_01_0_0_0;
      S_J:  return 16'b0_0_0_0_0_00_00_1_0_10_0_0_0;
      default: return 16'h0;
    endcase
  endfunction

  // R11 mapping
  function automatic logic [2:0] exp_fn(logic [1:0] mode, logic [5:0] f);
    if (mode == 2'b01) return 3'd1;
    if (mode != 2'b10) return 3'd0;
    case (f)
      6'b100010: return 3'd1;
      6'b100100: return 3'd2;
      6'b100101: return 3'd3;
      6'b101010: return 3'd4;
      default:   return 3'd0;
    endcase
  endfunction

  function automatic logic [18:0] exp_full(int s, logic [5:0] f);
    logic [15:0] v;
    v = exp_vec(s);
    return {v, exp_fn(v[8:7], f)};
  endfunction

  logic [18:0] exp_q[$];
  string       tag_q[$];
  logic [18:0] mon_e;
  string       mon_t;

  // Monitor: one expected item per cycle, sampled mid-cycle
  always @(negedge clk) begin
    if (!rst && exp_q.size() > 0) begin
      mon_e = exp_q.pop_front();
      mon_t = tag_q.pop_front();
      checks++;
      if (act !== mon_e) begin
        errors++;
        $display("FAIL %s act=%b exp=%b", mon_t, act, mon_e);
      end
    end
  end

  // Driver: push the whole expected cycle list, then let it run
  task automatic run_op(input logic [5:0] op, input logic [5:0] f,
                        input int keep, input string tag);
    int st[5];
    int len;
    int n;
    st[0] = S_F; st[1] = S_D; len = 2;
    case (op)
      6'b000000: begin st[2] = S_EX; st[3] = S_RW; len = 4; end
      6'b100011: begin st[2] = S_MA; st[3] = S_MR; st[4] = S_LW; len = 5; end
      6'b101011: begin st[2] = S_MA; st[3] = S_MW; len = 4; end
      6'b000100: begin st[2] = S_BR; len = 3; end
      6'b000010: begin st[2] = S_J;  len = 3; end
      default:   len = 2;
    endcase
    n = (keep < len) ? keep : len;
    opcode = op;
    funct  = f;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(exp_full(st[i], f));
      tag_q.push_back(tag);
    end
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic reset_check(input string tag);
    rst = 1'b1;
    @(posedge clk);
    #1;
    @(negedge clk);
    checks++;
    if (act !== exp_full(S_F, funct)) begin
      errors++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp_full(S_F, funct));
    end
    @(posedge clk);
    #1;
    rst = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    funct = 6'b100010;
    @(posedge clk);
    #1;
    reset_check("R1 reset state");
    run_op(6'b000000, 6'b100000, 9, "R7 R11 rr add");
    run_op(6'b000000, 6'b100010, 9, "R7 R11 rr sub");
    run_op(6'b000000, 6'b100100, 9, "R7 R11 rr and");
    run_op(6'b000000, 6'b100101, 9, "R7 R11 rr or");
    run_op(6'b000000, 6'b101010, 9, "R7 R11 rr slt");
    run_op(6'b000000, 6'b111111, 9, "R11 unknown funct");
    run_op(6'b100011, 6'b100010, 9, "R4 R5 R6 load");
    run_op(6'b101011, 6'b100101, 9, "R4 R5 store");
    run_op(6'b000100, 6'b101010, 9, "R8 branch");
    run_op(6'b000010, 6'b100100, 9, "R9 jump");
    run_op(6'b111000, 6'b100000, 9, "R10 unknown opcode");
    run_op(6'b000001, 6'b100000, 9, "R10 unknown opcode 2");
    run_op(6'b100011, 6'b000000, 3, "R2 R3 R12 partial load");
    reset_check("R1 mid-instruction reset");
    run_op(6'b000100, 6'b100010, 9, "R8 branch after reset");
    run_op(6'b100011, 6'b101010, 9, "R6 load after reset");
    repeat (2) @(posedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R12 queue act=%0d exp=0", exp_q.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule